// File: doc/BRIEF.md
# Modulating Infrared Pulse Transmitter

This block plays out a queue of mark and space durations on a single infrared output line. Software, or a neighbouring controller, writes words into an eight-entry queue. Each word holds a width count and a level bit. The block takes the words in order and holds each level for a time derived from a programmable clock prescaler. The words play back to back, with no idle cycle between them.

While carrier modulation is enabled, every pulse that should carry light is chopped by a square carrier. The carrier period is always sixteen prescaled ticks, and its high time is set in sixteenths of that period. A polarity bit chooses whether the burst is sent on marks or on spaces. While modulation is off, the output simply follows the level bit of the current word.

A service request flag tells the writer when the queue has room. It can be masked onto an interrupt line. When the last queued pulse has finished, the line returns to an idle low state.

Top module: `ir_tx_mod`

## Requirements
- R1: After a synchronous active-low reset, `ir_out`, `irq` and every bit of `status` are 0, the queue is empty, and every control bit, the divider and the duty setting are 0.
- R2: `wr_sel` picks the target of a write strobe: 0 is control, 1 is the prescaler divider (`wr_data[15:0]`), 2 is the duty setting (`wr_data[3:0]`) and 3 is a queue word. The control bits are: bit 0 enable, bit 1 modulation on, bit 2 polarity swap, bit 3 request only when empty, bit 5 interrupt enable.
- R3: A queue word carries a width count `c` in bits [15:0] and a level in bit 16, where 1 means mark. The pulse lasts 4*c+3 prescaled ticks, and a tick comes once every divider+1 clock cycles. The first pulse after enable starts one cycle after the enabling write, so it spans (4*c+3)*(divider+1) cycles.
- R4: With modulation on, the carrier period is 16 ticks. It is high for the first duty+1 ticks of each period and starts high when transmission begins from idle.
- R5: With modulation on and polarity swap clear, marks carry the carrier and spaces are low. With polarity swap set, spaces carry the carrier and marks are low.
- R6: With modulation off, `ir_out` equals the level bit of the current pulse, whatever the polarity bit says. Whenever no pulse is active, `ir_out` is 0.
- R7: The queue holds 8 words. A queue write while it already holds 8 words is discarded.
- R8: `status[5]` (service request) is 1 when enabled and the queue holds 4 or fewer words. If bit 3 of control is set, it is 1 only when enabled and the queue is empty. `irq` equals `status[5]` AND interrupt enable.
- R9: `status[3]` is 1 from the cycle a pulse starts until the last queued pulse completes, and it stays high across back-to-back pulses. The other status bits are always 0.
- R10: Clearing the enable bit aborts the running pulse: `status[3]` and `ir_out` are 0 from the second clock edge after the control write. Words still queued are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 2 | Write target select |
| wr_data | input | 17 | Write data |
| ir_out | output | 1 | Infrared drive line |
| irq | output | 1 | Masked service request interrupt |
| status | output | 6 | Bit 3 busy, bit 5 service request |

## Verification
The hardest state to reach is a queue holding exactly the watermark count while enabled. The engine pops a word as soon as it is idle, so the fill level cannot be set directly. The stimulus fills the queue while the block is disabled and uses a long prescaler setting. It then enables the block so that exactly one word is consumed, which leaves four queued words while the first pulse is still running. Both watermark modes and the abort path are checked from that state.

// File: rtl/irtx_pkg.sv
// Shared constants and types for the modulating infrared transmitter.
// Assumes the carrier is always 16 ticks long, so the duty field is 4 bits.
package irtx_pkg;
    localparam int CNT_W      = 16;
    localparam int DIV_W      = 16;
    localparam int FIFO_DEPTH = 8;
    localparam int WORD_W     = CNT_W + 1;
    localparam int PHASE_W    = 4;

    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_DIV  = 2'd1,
        SEL_DUTY = 2'd2,
        SEL_FIFO = 2'd3
    } sel_e;

    typedef struct packed {
        logic irq_en;
        logic wm_empty;
        logic pol_swap;
        logic mod_en;
        logic run;
    } ctrl_t;
endpackage

// File: rtl/irtx_fifo.sv
// Word queue for pulse descriptors.
// Assumes DEPTH is a power of two, so the pointers wrap naturally.
// A push while full is dropped, and pop is only raised when not empty.
module irtx_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 17,
    localparam int AW   = $clog2(DEPTH),
    localparam int FW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic [FW-1:0] fill,
    output logic          empty
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic          do_push;

    assign do_push = push && (fill != FW'(DEPTH));
    assign empty   = (fill == '0);
    assign dout    = mem[rp];

    // Storage write, no reset needed
    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= din;
    end

    // Pointer and fill-level bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp   <= '0;
            rp   <= '0;
            fill <= '0;
        end else begin
            if (do_push) wp <= wp + 1'b1;
            if (pop)     rp <= rp + 1'b1;
            case ({do_push, pop})
                2'b10:   fill <= fill + 1'b1;
                2'b01:   fill <= fill - 1'b1;
                default: fill <= fill;
            endcase
        end
    end
endmodule

// File: rtl/irtx_tick.sv
// Prescaler that emits one tick every div+1 cycles while run is high.
// It is held at zero while stopped, so the first tick follows enable at once.
module irtx_tick #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    assign tick = run && (cnt == '0);

    // Down counter that reloads from the divider
    always_ff @(posedge clk) begin
        if (!rst_n || !run)  cnt <= '0;
        else if (cnt == '0)  cnt <= div;
        else                 cnt <= cnt - 1'b1;
    end
endmodule

// File: rtl/irtx_pulse.sv
// Pulse timing engine: loads a word when idle or at the end of a pulse,
// then holds its level for 4*count+3 ticks.
// Assumes the queue presents its head word on 'word' whenever it is not empty.
module irtx_pulse #(
    parameter int CNT_W = 16,
    localparam int W    = CNT_W + 1,
    localparam int RW   = CNT_W + 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         tick,
    input  logic         q_empty,
    input  logic [W-1:0] word,
    output logic         pop,
    output logic         active,
    output logic         level
);
    logic [RW-1:0] remain;
    logic          slot_free;

    assign slot_free = !active || (tick && remain == '0);
    assign pop       = run && slot_free && !q_empty;

    // Load, count down and retire pulses
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            active <= 1'b0;
            remain <= '0;
            level  <= 1'b0;
        end else if (slot_free) begin
            active <= !q_empty;
            if (!q_empty) begin
                remain <= {word[CNT_W-1:0], 2'b10};
                level  <= word[CNT_W];
            end
        end else if (tick) begin
            remain <= remain - 1'b1;
        end
    end
endmodule

// File: rtl/irtx_carrier.sv
// 16-tick carrier phase counter with a programmable high time.
// The phase restarts at zero whenever the transmitter goes idle.
module irtx_carrier #(
    parameter int PHASE_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               active,
    input  logic               tick,
    input  logic [PHASE_W-1:0] duty,
    output logic               hi
);
    logic [PHASE_W-1:0] phase;

    assign hi = (phase <= duty);

    // Advance the phase once per tick while a pulse is running
    always_ff @(posedge clk) begin
        if (!rst_n || !active) phase <= '0;
        else if (tick)         phase <= phase + 1'b1;
    end
endmodule

// File: rtl/ir_tx_mod.sv
// Top of the modulating infrared transmitter.
// Holds the control, divider and duty registers, then wires the queue,
// prescaler, pulse engine and carrier into the output line.
// Assumes a single write port and no read-back path.
module ir_tx_mod
    import irtx_pkg::*;
#(
    parameter int CNT_W = irtx_pkg::CNT_W,
    parameter int DIV_W = irtx_pkg::DIV_W,
    parameter int DEPTH = irtx_pkg::FIFO_DEPTH,
    localparam int DW   = CNT_W + 1,
    localparam int FW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [1:0]    wr_sel,
    input  logic [DW-1:0] wr_data,
    output logic          ir_out,
    output logic          irq,
    output logic [5:0]    status
);
    localparam logic [FW-1:0] HALF = FW'(DEPTH / 2);

    ctrl_t              ctl;
    logic [DIV_W-1:0]   div_q;
    logic [PHASE_W-1:0] duty_q;
    logic               push, pop, q_empty, tick, active, level, car_hi;
    logic [DW-1:0]      head;
    logic [FW-1:0]      fifo_fill;
    logic               svc, burst;
    logic               ctl_en;

    assign push   = wr_en && (sel_e'(wr_sel) == SEL_FIFO);
    assign ctl_en = ctl.run;

    // Register write decode
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl    <= '0;
            div_q  <= '0;
            duty_q <= '0;
        end else if (wr_en) begin
            case (sel_e'(wr_sel))
                SEL_CTRL: ctl <= '{irq_en:   wr_data[5], wm_empty: wr_data[3],
                                   pol_swap: wr_data[2], mod_en:   wr_data[1],
                                   run:      wr_data[0]};
                SEL_DIV:  div_q  <= wr_data[DIV_W-1:0];
                SEL_DUTY: duty_q <= wr_data[PHASE_W-1:0];
                default:  ;
            endcase
        end
    end

    irtx_fifo #(.DEPTH(DEPTH), .W(DW)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(push), .din(wr_data),
        .pop(pop), .dout(head), .fill(fifo_fill), .empty(q_empty)
    );

    irtx_tick #(.DIV_W(DIV_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .run(ctl.run), .div(div_q), .tick(tick)
    );

    irtx_pulse #(.CNT_W(CNT_W)) u_pulse (
        .clk(clk), .rst_n(rst_n), .run(ctl.run), .tick(tick),
        .q_empty(q_empty), .word(head), .pop(pop),
        .active(active), .level(level)
    );

    irtx_carrier #(.PHASE_W(PHASE_W)) u_car (
        .clk(clk), .rst_n(rst_n), .active(active), .tick(tick),
        .duty(duty_q), .hi(car_hi)
    );

    // Output shaping, service request and status
    always_comb begin
        burst  = level ^ ctl.pol_swap;
        ir_out = active && (ctl.mod_en ? (burst && car_hi) : level);
        svc    = ctl.run && (ctl.wm_empty ? (fifo_fill == '0) : (fifo_fill <= HALF));
        irq    = svc && ctl.irq_en;
        status = {svc, 1'b0, active, 3'b000};
    end
endmodule

// File: rtl/irtx_chk.sv
// Property checker for the transmitter, attached to the top with bind.
module irtx_chk #(
    parameter int DEPTH = 8,
    parameter int FW    = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ir_out,
    input logic          irq,
    input logic [5:0]    status,
    input logic          run,
    input logic          wm_empty,
    input logic [FW-1:0] fill
);
    a_r6_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !status[3] |-> !ir_out);

    a_r8_irq_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> status[5]);

    a_r8_wm_empty_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (wm_empty && fill != '0) |-> !status[5]);

    a_r10_abort: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !status[3]);

    a_r7_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= FW'(DEPTH));
endmodule

bind ir_tx_mod irtx_chk #(.DEPTH(DEPTH), .FW(FW)) u_chk (
    .clk(clk), .rst_n(rst_n), .ir_out(ir_out), .irq(irq), .status(status),
    .run(ctl_en), .wm_empty(ctl.wm_empty), .fill(fifo_fill)
);

// File: tb/test_ir_tx_mod.sv
module test_ir_tx_mod;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = '0;
    logic [16:0] wr_data = '0;
    logic        ir_out, irq;
    logic [5:0]  status;
    int total = 0;
    int bad = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    ir_tx_mod i_ir_tx_mod (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .ir_out(ir_out), .irq(irq), .status(status)
    );

    typedef struct packed {
        logic [15:0] dv;
        logic [15:0] cn;
        logic        lv;
        logic        md;
        logic        pl;
        logic [3:0]  dt;
    } vec_t;

    localparam vec_t TBL [7] = '{
        {16'd0, 16'd2, 1'b1, 1'b0, 1'b0, 4'd0},
        {16'd0, 16'd3, 1'b1, 1'b1, 1'b0, 4'd7},
        {16'd0, 16'd5, 1'b1, 1'b1, 1'b1, 4'd3},
        {16'd0, 16'd5, 1'b0, 1'b1, 1'b1, 4'd3},
        {16'd2, 16'd1, 1'b1, 1'b1, 1'b0, 4'd0},
        {16'd1, 16'd0, 1'b0, 1'b0, 1'b1, 4'd15},
        {16'd0, 16'd4, 1'b1, 1'b1, 1'b0, 4'd15}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] s, input logic [16:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Count busy cycles and high output cycles until busy falls
    task automatic measure(output int len, output int hi);
        bit seen = 0;
        len = 0; hi = 0;
        for (int g = 0; g < 20000; g++) begin
            @(negedge clk);
            if (status[3]) begin
                seen = 1; len++;
                if (ir_out) hi++;
            end else if (seen) break;
        end
    endtask

    function automatic void model(input vec_t v, output int len, output int hi);
        int ph;
        bit on;
        len = (4 * int'(v.cn) + 3) * (int'(v.dv) + 1);
        hi = 0;
        for (int j = 0; j < len; j++) begin
            ph = (j / (int'(v.dv) + 1)) % 16;
            on = v.md ? ((v.lv ^ v.pl) && ph <= int'(v.dt)) : v.lv;
            if (on) hi++;
        end
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int len, hi, elen, ehi;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(status == 6'd0, "R1 status", int'(status), 0);
        chk(ir_out == 1'b0, "R1 ir_out", int'(ir_out), 0);
        chk(irq == 1'b0, "R1 irq", int'(irq), 0);

        // R2 R3 R4 R5 R6 R9: table of single pulses
        foreach (TBL[k]) begin
            wr(2'd0, 17'd0);
            wr(2'd1, {1'b0, TBL[k].dv});
            wr(2'd2, {13'd0, TBL[k].dt});
            wr(2'd3, {TBL[k].lv, TBL[k].cn});
            wr(2'd0, {14'd0, TBL[k].pl, TBL[k].md, 1'b1});
            measure(len, hi);
            model(TBL[k], elen, ehi);
            chk(len == elen, "R3 R9 pulse length", len, elen);
            chk(hi == ehi, "R4 R5 R6 high cycles", hi, ehi);
        end

        // R7 R9: 10 writes into an idle queue, only 8 kept, played without gaps
        wr(2'd0, 17'd0);
        wr(2'd1, 17'd0);
        for (int i = 0; i < 10; i++) wr(2'd3, {1'b1, 16'd0});
        wr(2'd0, 17'd1);
        measure(len, hi);
        chk(len == 24, "R7 R9 queued length", len, 24);
        chk(hi == 24, "R9 no gaps", hi, 24);

        // R8: service request and interrupt
        wr(2'd0, 17'd0);
        wr(2'd1, 17'd1000);
        for (int i = 0; i < 5; i++) wr(2'd3, {1'b1, 16'd100});
        wr(2'd0, 17'h21);
        @(negedge clk);
        chk(status[5] == 1'b1, "R8 request at four", int'(status[5]), 1);
        chk(irq == 1'b1, "R8 irq", int'(irq), 1);
        chk(status[3] == 1'b1, "R9 busy", int'(status[3]), 1);
        wr(2'd0, 17'h29);
        chk(status[5] == 1'b0, "R8 empty-only mode", int'(status[5]), 0);
        chk(irq == 1'b0, "R8 irq masked by request", int'(irq), 0);
        wr(2'd3, {1'b1, 16'd100});
        wr(2'd0, 17'h01);
        chk(status[5] == 1'b0, "R8 request above four", int'(status[5]), 0);

        // R10: abort keeps queued words
        wr(2'd0, 17'h00);
        @(negedge clk);
        chk(status[3] == 1'b0, "R10 busy after abort", int'(status[3]), 0);
        chk(ir_out == 1'b0, "R10 ir_out after abort", int'(ir_out), 0);
        wr(2'd0, 17'h01);
        @(negedge clk);
        chk(status[5] == 1'b1, "R10 queue kept (four left)", int'(status[5]), 1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule